// File: doc/BRIEF.md
# Parity-Selectable UART

This block is a full-duplex asynchronous serial link with one transmitter and one receiver. Both share a two-bit parity selector with four settings: even, odd, forced-zero and none. The transmitter accepts a byte through a valid/ready handshake and shifts out a frame on a single line. The frame is a low start bit, the data bits least significant first, a parity bit when the mode has one, and a high stop bit.

The receiver passes the line through a two-stage synchronizer and watches it for a falling edge. At half a bit time it checks the start bit again, so that short low glitches are thrown away. After that it samples each following bit at its centre. Bit timing on both sides comes from an external enable, `tick16`, which pulses sixteen times per bit period. At the end of each frame the receiver presents the byte, a parity error flag and a framing error flag, together with a one-cycle valid pulse.

Top module: `uart_pm`

## Requirements
- R1: After reset `tx_ready` is 1, `tx_line` is 1 and `rx_valid` is 0.
- R2: A byte is taken only on a cycle where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from that cycle until the frame ends. A byte offered while the transmitter is busy is not sent, and nothing is queued from it.
- R3: The mode encoding is 00 = none, 01 = forced zero, 10 = odd, 11 = even. A transmitted frame is a 0 start bit, then 8 data bits LSB first, then the parity bit unless the mode is 00, then a 1 stop bit. Each bit lasts 16 `tick16` pulses, and the line stays at 1 between frames.
- R4: In mode 11 the transmitted parity bit is the XOR of the data bits, so the frame carries an even number of ones.
- R5: In mode 10 the transmitted parity bit is the inverse of the XOR of the data bits, so the frame carries an odd number of ones.
- R6: In mode 01 the transmitted parity bit is always 0. The receiver skips over the parity position and never raises `rx_par_err`, whatever that bit holds.
- R7: In mode 00 the frame is 10 bits long. The receiver treats the bit after the data as the stop bit and never raises `rx_par_err`.
- R8: In mode 11 the receiver raises `rx_par_err` when the count of ones in the data plus the parity bit is odd.
- R9: In mode 10 the receiver raises `rx_par_err` when the count of ones in the data plus the parity bit is even.
- R10: A stop bit sampled as 0 sets `rx_frm_err`. A stop bit sampled as 1 clears it.
- R11: A low pulse that ends before the middle of the start bit produces no received frame.
- R12: `rx_valid` is high for exactly one cycle per frame. `rx_data`, `rx_par_err` and `rx_frm_err` for that frame are valid during that cycle.
- R13: Each side samples the mode when its frame starts. A change of `par_mode` during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| par_mode | input | 2 | Parity mode select |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| tx_line | output | 1 | Serial output line |
| rx_line | input | 1 | Serial input line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_par_err | output | 1 | Parity error of the last frame |
| rx_frm_err | output | 1 | Framing error of the last frame |

## Verification
A single received frame can produce a parity error and a framing error in the same cycle, and the block has to report both on one valid pulse. To provoke this, the bench drives the receive line directly with an even-mode frame whose parity bit is wrong and whose stop bit is 0. The check expects both flags high and the data intact in the single cycle where `rx_valid` is high. Separate frames with only one of the two faults confirm that each flag depends only on its own cause.

// File: rtl/uart_pm.sv
module uart_pm #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic [1:0]    par_mode,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tx_line,
  input  logic          rx_line,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_par_err,
  output logic          rx_frm_err
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FW + 1);
  localparam logic [CW-1:0] LASTC = CW'(OVS - 1);
  localparam logic [CW-1:0] MIDC  = CW'(OVS / 2 - 1);

  // transmitter
  logic          tx_busy;
  logic [FW-1:0] tx_sh;
  logic [CW-1:0] tx_cnt;
  logic [BW-1:0] tx_idx, tx_last;

  wire tx_par = par_mode[1] & (^tx_data ^ ~par_mode[0]);
  wire tx_go  = tx_valid & ~tx_busy;

  assign tx_ready = ~tx_busy;
  assign tx_line  = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_idx  <= '0;
      tx_last <= '0;
    end else if (tx_go) begin
      tx_busy <= 1'b1;
      tx_cnt  <= '0;
      tx_idx  <= '0;
      if (par_mode == 2'b00) begin
        tx_sh   <= {2'b11, tx_data, 1'b0};
        tx_last <= BW'(FW - 2);
      end else begin
        tx_sh   <= {1'b1, tx_par, tx_data, 1'b0};
        tx_last <= BW'(FW - 1);
      end
    end else if (tx_busy && tick16) begin
      if (tx_cnt == LASTC) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[FW-1:1]};
        if (tx_idx == tx_last) tx_busy <= 1'b0;
        else                   tx_idx  <= tx_idx + 1'b1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  // receiver
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS, R_STOP} rx_st_t;
  rx_st_t        rx_st;
  logic [1:0]    rx_s;
  logic          rx_q;
  logic [1:0]    rx_mode;
  logic [DW:0]   rx_sh;
  logic [CW-1:0] rx_cnt;
  logic [BW-1:0] rx_idx;

  wire          rx_in    = rx_s[1];
  wire [BW-1:0] rx_lasti = (rx_mode == 2'b00) ? BW'(DW - 1) : BW'(DW);
  wire [DW-1:0] rx_byte  = (rx_mode == 2'b00) ? rx_sh[DW:1] : rx_sh[DW-1:0];
  wire          rx_perr  = rx_mode[1] & (^rx_sh ^ ~rx_mode[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s       <= 2'b11;
      rx_q       <= 1'b1;
      rx_st      <= R_IDLE;
      rx_mode    <= 2'b00;
      rx_sh      <= '0;
      rx_cnt     <= '0;
      rx_idx     <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_s     <= {rx_s[0], rx_line};
      rx_q     <= rx_in;
      rx_valid <= 1'b0;
      case (rx_st)
        R_IDLE: if (rx_q && !rx_in) begin
          rx_st   <= R_START;
          rx_cnt  <= '0;
          rx_mode <= par_mode;
        end
        R_START: if (tick16) begin
          if (rx_cnt == MIDC) begin
            rx_cnt <= '0;
            rx_idx <= '0;
            rx_st  <= rx_in ? R_IDLE : R_BITS;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        R_BITS: if (tick16) begin
          if (rx_cnt == LASTC) begin
            rx_cnt <= '0;
            rx_sh  <= {rx_in, rx_sh[DW:1]};
            if (rx_idx == rx_lasti) rx_st  <= R_STOP;
            else                    rx_idx <= rx_idx + 1'b1;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        default: if (tick16) begin
          if (rx_cnt == LASTC) begin
            rx_st      <= R_IDLE;
            rx_valid   <= 1'b1;
            rx_data    <= rx_byte;
            rx_par_err <= rx_perr;
            rx_frm_err <= ~rx_in;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
      endcase
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_line);
  p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_line && !tx_ready));
  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tick16) |=> ($stable(tx_line) && !tx_ready));
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_nocheck_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_mode[1]) |-> !rx_par_err);
  p_glitch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st == R_START && tick16 && rx_cnt == MIDC && rx_in) |=> (rx_st == R_IDLE && !rx_valid));
endmodule

// File: tb/uart_pm_test.sv
module uart_pm_test;
  logic       clk = 0, rst_n = 0, tick16 = 1, slow = 0;
  logic [1:0] par_mode = 2'b00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 0, loop = 1, drv = 1;
  wire        tx_ready, tx_line, rx_valid, rx_par_err, rx_frm_err;
  wire [7:0]  rx_data;
  wire        rx_line = loop ? tx_line : drv;
  int checks = 0, fails = 0, cyc = 0;

  uart_pm uut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .par_mode(par_mode),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    tick16 <= slow ? ~tick16 : 1'b1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // {mode, data}
  localparam logic [9:0] VEC [8] = '{
    {2'b11, 8'h00}, {2'b11, 8'h01}, {2'b11, 8'hA5}, {2'b10, 8'h00},
    {2'b10, 8'h80}, {2'b10, 8'hFF}, {2'b01, 8'hFF}, {2'b00, 8'h5A}};

  function automatic logic exp_par(input logic [1:0] m, input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    if (m == 2'b11) return n % 2 == 1;
    if (m == 2'b10) return n % 2 == 0;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_rx(input int lim, output bit got, output logic [7:0] d,
                         output bit pe, output bit fe, output bit once);
    got = 0; d = 0; pe = 0; fe = 0; once = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rx_valid) begin
        got = 1; d = rx_data; pe = rx_par_err; fe = rx_frm_err;
        @(negedge clk);
        once = !rx_valid;
        break;
      end
    end
  endtask

  task automatic tx_frame(input logic [1:0] m, input logic [1:0] nxt,
                          input logic [7:0] d, input bit poke, input string tag);
    int bc = slow ? 32 : 16;
    bit got, pe, fe, once;
    logic [7:0] rd;
    loop = 1;
    @(negedge clk);
    par_mode = m; tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    chk(tx_ready == 0, {tag, " R2 ready low after accept"}, tx_ready, 0);
    repeat (bc / 2) @(negedge clk);
    chk(tx_line == 0, {tag, " R3 start bit"}, tx_line, 0);
    par_mode = nxt;
    if (poke) begin tx_valid = 1; tx_data = ~d; end
    for (int i = 0; i < 8; i++) begin
      repeat (bc) @(negedge clk);
      chk(tx_line == d[i], {tag, " R3 data bit"}, tx_line, d[i]);
      if (poke) chk(tx_ready == 0, {tag, " R2 ready low while busy"}, tx_ready, 0);
    end
    if (m != 2'b00) begin
      repeat (bc) @(negedge clk);
      chk(tx_line == exp_par(m, d), {tag, " R4 R5 R6 parity bit"}, tx_line, exp_par(m, d));
    end
    if (poke) tx_valid = 0;
    repeat (bc) @(negedge clk);
    chk(tx_line == 1, {tag, " R3 stop bit"}, tx_line, 1);
    wait_rx(2 * bc, got, rd, pe, fe, once);
    chk(got && rd == d, {tag, " R12 loopback data"}, rd, d);
    chk(!pe && !fe, {tag, " R8 R9 no error on clean frame"}, {pe, fe}, 0);
    chk(once, {tag, " R12 valid one cycle"}, !once, 0);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic rx_inject(input logic [1:0] m, input logic [7:0] d, input logic pb,
                           input logic sb, output bit got, output logic [7:0] rd,
                           output bit pe, output bit fe, output bit once);
    loop = 0; par_mode = m;
    @(negedge clk);
    drv = 0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv = d[i];
      repeat (16) @(negedge clk);
    end
    if (m != 2'b00) begin
      drv = pb;
      repeat (16) @(negedge clk);
    end
    drv = sb;
    wait_rx(14, got, rd, pe, fe, once);
    drv = 1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    bit got, pe, fe, once;
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready == 1, "R1 ready after reset", tx_ready, 1);
    chk(tx_line == 1, "R1 line idle high", tx_line, 1);
    chk(rx_valid == 0, "R1 no rx valid", rx_valid, 0);

    for (int v = 0; v < 8; v++)
      tx_frame(VEC[v][9:8], VEC[v][9:8], VEC[v][7:0], 0, "vec");

    // R2: offered byte during busy frame is ignored, nothing queued
    tx_frame(2'b11, 2'b11, 8'h96, 1, "busy");
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (tx_line != 1) begin chk(0, "R2 no queued frame", tx_line, 1); break; end
    end
    chk(tx_ready == 1, "R2 ready after frame", tx_ready, 1);

    // R13: mode switched to none mid-frame
    tx_frame(2'b11, 2'b00, 8'h07, 0, "modeswap R13");
    tx_frame(2'b00, 2'b10, 8'h3C, 0, "modeswap2 R13");

    // R3: half-rate tick
    slow = 1;
    tx_frame(2'b11, 2'b11, 8'hC3, 0, "slow R3");
    slow = 0;
    repeat (4) @(negedge clk);

    rx_inject(2'b11, 8'h31, 1'b0, 1'b1, got, rd, pe, fe, once);
    chk(got && pe && !fe && rd == 8'h31, "R8 even bad parity", {got, pe, fe}, 3'b110);
    rx_inject(2'b11, 8'h31, 1'b1, 1'b1, got, rd, pe, fe, once);
    chk(got && !pe && !fe, "R8 even good parity", {got, pe, fe}, 3'b100);
    rx_inject(2'b10, 8'h0F, 1'b0, 1'b1, got, rd, pe, fe, once);
    chk(got && pe && !fe, "R9 odd bad parity", {got, pe, fe}, 3'b110);
    rx_inject(2'b10, 8'h0F, 1'b1, 1'b1, got, rd, pe, fe, once);
    chk(got && !pe && rd == 8'h0F, "R9 odd good parity", {got, pe}, 2'b10);
    rx_inject(2'b01, 8'hE2, 1'b1, 1'b1, got, rd, pe, fe, once);
    chk(got && !pe && !fe && rd == 8'hE2, "R6 forced zero ignores parity 1", {got, pe, rd}, {2'b10, 8'hE2});
    rx_inject(2'b00, 8'h6D, 1'b0, 1'b1, got, rd, pe, fe, once);
    chk(got && !pe && !fe && rd == 8'h6D, "R7 no-parity 10-bit frame", {got, pe, fe, rd}, {3'b100, 8'h6D});
    rx_inject(2'b10, 8'h55, 1'b1, 1'b0, got, rd, pe, fe, once);
    chk(got && !pe && fe, "R10 framing error", {got, pe, fe}, 3'b101);
    rx_inject(2'b10, 8'h55, 1'b1, 1'b1, got, rd, pe, fe, once);
    chk(got && !fe, "R10 framing clears", fe, 0);
    rx_inject(2'b11, 8'hA4, 1'b0, 1'b0, got, rd, pe, fe, once);
    chk(got && pe && fe && rd == 8'hA4, "R12 both flags same pulse", {pe, fe, rd}, {2'b11, 8'hA4});
    chk(once, "R12 valid one cycle injected", !once, 0);

    // R11: short low glitch
    loop = 0; drv = 1;
    @(negedge clk);
    drv = 0;
    repeat (4) @(negedge clk);
    drv = 1;
    wait_rx(60, got, rd, pe, fe, once);
    chk(!got, "R11 glitch rejected", got, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule